// File: doc/BRIEF.md
# Core Debug State Controller

This block moves a processor core subsystem between normal execution and a debug state. Any of four halt sources can start entry. The first is a dedicated external debug request pin. The second is a strobe that the core raises when it decodes a debug instruction. The third is an event pulse from the debug/profiling unit, which counts only while its enable is set. The fourth is a bus write of a parameterised code word to a control register.

Entry takes place in two phases. Instruction issue is halted in the first cycle of debug. The subsystem then drains for a programmable number of cycles. After that the activity flag (`busy`) drops, so that an external status read can see the subsystem is quiet. The block leaves debug only on a resume command from the external debug port or on reset. A cause field records which source started the current or most recent debug session.

The controller has three states. `ST_RUN` means normal execution. `ST_DRAIN` means issue is halted and activity is still draining. `ST_HALTED` means issue is halted and the subsystem is quiet. The transitions are:
- RUN→DRAIN on any valid halt source.
- DRAIN→HALTED when the drain count expires.
- DRAIN→RUN or HALTED→RUN on `resume_req`.
- Any state→RUN on reset.

Top module: `dbg_state_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `core_halt` is 0, `busy` is 1 and `entry_cause` is 0 until a halt source fires.
- R2: In run state, `ext_dbg_req` high at a clock edge makes `core_halt` 1 after that edge, with `entry_cause` = 1.
- R3: In run state, `dbg_instr` high at an edge enters debug with `entry_cause` = 2.
- R4: In run state, `evt_pulse` enters debug with `entry_cause` = 3 only when `evt_enable` is 1. With `evt_enable` at 0 the pulse has no effect.
- R5: In run state, `reg_wr_en` with `reg_wr_data` equal to parameter MAGIC enters debug with `entry_cause` = 4. A write of any other value has no effect.
- R6: When several sources fire in the same cycle, the cause is chosen in this priority order: external pin (1), then instruction (2), then event (3), then register write (4).
- R7: `busy` stays 1 for exactly N cycles after the entry edge and then reads 0. N is `drain_count` sampled at entry, and a value of 0 is treated as 1.
- R8: While in debug state, all halt sources are ignored: `core_halt` stays 1 and `entry_cause` keeps its value.
- R9: `resume_req` in either debug state returns to run after the next edge, with `busy` = 1 and `entry_cause` kept. `resume_req` in run state has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_dbg_req | input | 1 | Dedicated external debug request |
| dbg_instr | input | 1 | Core decoded a debug instruction |
| evt_pulse | input | 1 | Debug unit event pulse |
| evt_enable | input | 1 | Enables event-triggered entry |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | DATA_W | Control register write data |
| drain_count | input | CNT_W | Drain delay in cycles (0 treated as 1) |
| resume_req | input | 1 | Resume command from the external debug port |
| core_halt | output | 1 | Halt instruction issue (1 = in debug) |
| busy | output | 1 | Subsystem activity flag, 0 once drained |
| entry_cause | output | 3 | Cause of the last entry: 0 none, 1 pin, 2 instruction, 3 event, 4 register |

## Verification
The bench targets four areas:
- **Drain boundaries.** It uses N=1, N=0 and N=255. A timer that is off by one drops `busy` a cycle early or late, and a zero count that is not clamped would hang in drain.
- **Rejected triggers.** It sends a near-miss register value and an event pulse while its enable is off. A design that decodes loosely would halt the core.
- **Priority.** It fires several sources in the same cycle. A reversed or incomplete encoder would record the wrong cause.
- **Sessions.** It re-triggers sources during drain and during halt, and it sends resume during drain and while running. A design that re-arms on these would overwrite the cause or restart the drain.

// File: rtl/dbg_state_pkg.sv
package dbg_state_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HALTED = 2'd2
    } dbg_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_EXT   = 3'd1,
        CAUSE_INSTR = 3'd2,
        CAUSE_EVENT = 3'd3,
        CAUSE_REGWR = 3'd4
    } dbg_cause_e;

endpackage

// File: rtl/dbg_src_arbiter.sv
module dbg_src_arbiter
    import dbg_state_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] MAGIC = 32'hD0DE_0A11
) (
    input  logic              ext_dbg_req,
    input  logic              dbg_instr,
    input  logic              evt_pulse,
    input  logic              evt_enable,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              any_src,
    output dbg_cause_e        src_cause
);
    localparam int NUM_SRC = 4;

    logic [NUM_SRC-1:0] src_vec;

    assign src_vec[0] = ext_dbg_req;
    assign src_vec[1] = dbg_instr;
    assign src_vec[2] = evt_pulse & evt_enable;
    assign src_vec[3] = reg_wr_en & (reg_wr_data == MAGIC);

    assign any_src = |src_vec;

    // lowest index wins
    always_comb begin
        src_cause = CAUSE_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src_vec[i]) src_cause = dbg_cause_e'(i + 1);
        end
    end
endmodule

// File: rtl/dbg_drain_timer.sv
module dbg_drain_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             run,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= ONE;
            cnt_q   <= '0;
        end else if (load) begin
            limit_q <= (limit_in == '0) ? ONE : limit_in;
            cnt_q   <= '0;
        end else if (run) begin
            cnt_q   <= done ? '0 : cnt_q + ONE;
        end
    end

    assign done = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit_q};
endmodule

// File: rtl/dbg_state_ctrl.sv
module dbg_state_ctrl
    import dbg_state_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          CNT_W  = 8,
    parameter logic [DATA_W-1:0] MAGIC = 32'hD0DE_0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_dbg_req,
    input  logic              dbg_instr,
    input  logic              evt_pulse,
    input  logic              evt_enable,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [CNT_W-1:0]  drain_count,
    input  logic              resume_req,
    output logic              core_halt,
    output logic              busy,
    output logic [2:0]        entry_cause
);
    dbg_state_e state_q, state_d;
    dbg_cause_e cause_q, src_cause;
    logic       any_src;
    logic       drain_done;
    logic       enter;

    dbg_src_arbiter #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_arb (
        .ext_dbg_req (ext_dbg_req),
        .dbg_instr   (dbg_instr),
        .evt_pulse   (evt_pulse),
        .evt_enable  (evt_enable),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .any_src     (any_src),
        .src_cause   (src_cause)
    );

    assign enter = (state_q == ST_RUN) && any_src;

    dbg_drain_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter),
        .limit_in (drain_count),
        .run      (state_q == ST_DRAIN),
        .done     (drain_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (any_src)         state_d = ST_DRAIN;
            ST_DRAIN:  if (resume_req)      state_d = ST_RUN;
                       else if (drain_done) state_d = ST_HALTED;
            ST_HALTED: if (resume_req)      state_d = ST_RUN;
            default:                        state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            if (enter) cause_q <= src_cause;
        end
    end

    // outputs
    always_comb begin
        core_halt   = (state_q != ST_RUN);
        busy        = (state_q != ST_HALTED);
        entry_cause = cause_q;
    end
endmodule

// File: rtl/dbg_state_ctrl_chk.sv
module dbg_state_ctrl_chk #(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] MAGIC = 32'hD0DE_0A11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_dbg_req,
    input logic              dbg_instr,
    input logic              evt_pulse,
    input logic              evt_enable,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              resume_req,
    input logic              core_halt,
    input logic              busy,
    input logic [2:0]        entry_cause
);
    // R1
    run_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_halt |-> busy);

    // R2
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && ext_dbg_req) |=> (core_halt && entry_cause == 3'd1));

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && reg_wr_en && reg_wr_data != MAGIC && !ext_dbg_req
         && !dbg_instr && !(evt_pulse && evt_enable)) |=> !core_halt);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !core_halt);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && !resume_req) |=> (core_halt && $stable(entry_cause)));

    // R9
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && resume_req) |=> (!core_halt && busy && $stable(entry_cause)));
endmodule

bind dbg_state_ctrl dbg_state_ctrl_chk #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_dbg_req (ext_dbg_req),
    .dbg_instr   (dbg_instr),
    .evt_pulse   (evt_pulse),
    .evt_enable  (evt_enable),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .resume_req  (resume_req),
    .core_halt   (core_halt),
    .busy        (busy),
    .entry_cause (entry_cause)
);

// File: tb/dbg_state_ctrl_tb.sv
module dbg_state_ctrl_tb;
    localparam int          DATA_W = 32;
    localparam int          CNT_W  = 8;
    localparam logic [31:0] MAGIC  = 32'hD0DE_0A11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_dbg_req = 1'b0, dbg_instr = 1'b0, evt_pulse = 1'b0, evt_enable = 1'b0;
    logic              reg_wr_en = 1'b0, resume_req = 1'b0;
    logic [DATA_W-1:0] reg_wr_data = '0;
    logic [CNT_W-1:0]  drain_count = '0;
    logic              core_halt, busy;
    logic [2:0]        entry_cause;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic  halt;
        logic  busy;
        logic [2:0] cause;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // requirement-level model state
    bit       m_act = 0;
    bit       m_busy = 1;
    int       m_cnt = 0;
    int       m_lim = 1;
    bit [2:0] m_cause = 0;

    always #5 clk = ~clk;

    dbg_state_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MAGIC(MAGIC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_dbg_req(ext_dbg_req), .dbg_instr(dbg_instr),
        .evt_pulse(evt_pulse), .evt_enable(evt_enable), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .drain_count(drain_count), .resume_req(resume_req),
        .core_halt(core_halt), .busy(busy), .entry_cause(entry_cause)
    );

    task automatic check(input logic h, input logic b, input logic [2:0] c, input string tag);
        checks++;
        if (core_halt !== h || busy !== b || entry_cause !== c) begin
            failures++;
            $display("FAIL %s: got halt=%0b busy=%0b cause=%0d, expected halt=%0b busy=%0b cause=%0d",
                     tag, core_halt, busy, entry_cause, h, b, c);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(input bit ext, input bit ins, input bit evt, input bit en,
                        input bit wr, input logic [31:0] data, input bit res,
                        input int dc, input string tag);
        exp_t e;
        @(negedge clk);
        ext_dbg_req = ext; dbg_instr = ins; evt_pulse = evt; evt_enable = en;
        reg_wr_en = wr; reg_wr_data = data; resume_req = res; drain_count = CNT_W'(dc);
        if (m_act) begin
            if (res) begin
                m_act = 0; m_busy = 1;
            end else if (m_busy) begin
                m_cnt++;
                if (m_cnt >= m_lim) m_busy = 0;
            end
        end else begin
            bit [2:0] src = 0;
            if (wr && data == MAGIC) src = 3'd4;
            if (evt && en)           src = 3'd3;
            if (ins)                 src = 3'd2;
            if (ext)                 src = 3'd1;
            if (src != 0) begin
                m_act = 1; m_cause = src; m_busy = 1; m_cnt = 0;
                m_lim = (dc == 0) ? 1 : dc;
            end
        end
        e.halt = m_act; e.busy = m_busy; e.cause = m_cause; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 4, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.halt, e.busy, e.cause, e.tag);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 check(0, 1, 0, "R1 reset");
        @(negedge clk) rst_n = 1'b1;
        idle(3, "R1 idle");
        // R2 external pin, drain 3
        step(1, 0, 0, 0, 0, 0, 0, 3, "R2 ext entry");
        idle(5, "R7 drain 3");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        idle(2, "R9 run");
        // R3 instruction, drain 1
        step(0, 1, 0, 0, 0, 0, 0, 1, "R3 instr entry");
        idle(3, "R7 drain 1");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        // R4 event gating
        step(0, 0, 1, 0, 0, 0, 0, 4, "R4 event disabled");
        idle(2, "R4 ignored");
        step(0, 0, 1, 1, 0, 0, 0, 0, "R4 event entry, R7 zero count");
        idle(3, "R7 drain 0 as 1");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        // R5 register write
        step(0, 0, 0, 0, 1, MAGIC ^ 32'h1, 0, 4, "R5 wrong code");
        idle(2, "R5 ignored");
        step(0, 0, 0, 0, 1, MAGIC, 0, 255, "R5 magic entry");
        idle(10, "R7 drain 255");
        step(1, 1, 1, 1, 1, MAGIC, 0, 4, "R8 sources during drain");
        idle(250, "R7 drain 255");
        step(1, 0, 0, 0, 0, 0, 0, 4, "R8 source while halted");
        step(0, 1, 1, 1, 0, 0, 0, 4, "R8 source while halted");
        idle(2, "R8 hold");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        // R6 priority
        step(1, 1, 1, 1, 1, MAGIC, 0, 2, "R6 all sources");
        idle(3, "R6 drain");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        step(0, 1, 1, 1, 1, MAGIC, 0, 2, "R6 instr wins");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume during drain");
        step(0, 0, 1, 1, 1, MAGIC, 0, 2, "R6 event wins");
        idle(3, "R6 drain");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9 resume in run");
        idle(2, "R9 run");
        @(posedge clk);
        #4;
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule